// File: doc/BRIEF.md
# Receive Status and Interrupt Controller

This block sits between a serial receiver's character assembler and a host bus. It holds one received character together with the error flags that arrived with it. It presents these as an 8-bit status word. It raises one interrupt pulse per received word, on either a buffer-full channel or a receive-error channel.

Flags stay frozen with the word they describe until the host reads the data buffer. An overrun is reported only when the host reads the buffer. A break that starts while the buffer is occupied is also reported only at that data read. A break that ends before the host has read the status is announced when the status is read.

The host should read the status first and the data second. After an overrun has been reported, the block raises `asm_hold` and drops incoming characters until the next status read.

Top module: `rx_stat_irq_ctrl`

## Requirements
- R1: While reset is active and after it, every status bit is zero except bit 2 and bit 0. Bit 2 follows `char_busy` and bit 0 follows `rx_en`. Both interrupt outputs and `asm_hold` are low.
- R2: The status layout is: bit7 buffer full, bit6 overrun, bit5 parity error, bit4 framing error, bit3 break, bit2 character in progress, bit1 sync found, bit0 receiver enabled. A `char_done` strobe into an empty buffer with `asm_hold` low has these effects in the next cycle: `data_out` holds the character, bit7 is set, and bits 5, 4 and 1 hold the strobe's parity, framing and sync indications.
- R3: Each word produces one interrupt, a single-cycle pulse in the cycle after the strobe that caused it. The pulse goes on `irq_err` when the word carries an error and `err_ie` is high. Otherwise it goes on `irq_full`. `irq_err` and `irq_full` are never high together.
- R4: A `char_done` while the buffer is full leaves `data_out` and bits 5, 4 and 1 unchanged and raises no interrupt.
- R5: After an overrun, bit6 is set and an error-class interrupt is pulsed in the cycle after the next `rd_data`, not before.
- R6: From the moment bit6 is set until the next `rd_stat`, `asm_hold` is high and `char_done` is ignored.
- R7: `rd_data` clears bit7. `rd_stat` clears bit6, bit3 and `asm_hold`.
- R8: A `brk_start` while the buffer is empty sets bit3 and pulses an error-class interrupt in the next cycle. This includes the case where bit6 is already set.
- R9: A `brk_start` while the buffer is full changes nothing until `rd_data`. At that read, bit3 is set with one error-class interrupt. Bit6 is also set only if a word was lost in the meantime.
- R10: A `brk_end` raises an error-class interrupt at once if no break is reported or pending. Otherwise the interrupt is raised at the first `rd_stat` after the pending break has been reported.
- R11: With `rx_en` low, neither interrupt pulses. With `full_ie` low, `irq_full` never pulses. An error-class interrupt means `irq_err` when `err_ie` is high, and `irq_full` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enabled; gates both interrupts |
| char_busy | input | 1 | Character assembly in progress, shown in status bit 2 |
| char_done | input | 1 | Strobe: a complete character is offered |
| char_data | input | DW | Character offered with `char_done` |
| char_pe | input | 1 | Parity error for the offered character |
| char_fe | input | 1 | Framing error for the offered character |
| char_sync | input | 1 | Sync word matched for the offered character |
| brk_start | input | 1 | Strobe: line break began |
| brk_end | input | 1 | Strobe: line break ended |
| err_ie | input | 1 | Error channel enable |
| full_ie | input | 1 | Buffer-full channel enable |
| rd_stat | input | 1 | Strobe: host reads the status word |
| rd_data | input | 1 | Strobe: host reads the data buffer |
| stat | output | 8 | Status word (layout in R2) |
| data_out | output | DW | Buffered character |
| irq_full | output | 1 | Buffer-full interrupt pulse |
| irq_err | output | 1 | Receive-error interrupt pulse |
| asm_hold | output | 1 | Receiver must not assemble new characters |

## Verification
The assertions assume that at most one of `char_done`, `brk_start`, `brk_end`, `rd_stat` and `rd_data` is high in any cycle. The clear-on-read and frozen-flag properties depend on this, because two strobes in the same cycle would have competing effects.

The stimulus therefore picks exactly one operation per cycle, either from directed sequences or from `$urandom`. Enable inputs change only on operation-free cycles. Break start and end strobes are issued in arbitrary order, which the properties tolerate.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FULL  = 2'd1,
        ST_OVRUN = 2'd2
    } buf_state_e;

    localparam int STAT_W  = 8;
    localparam int SB_FULL = 7;
    localparam int SB_OE   = 6;
    localparam int SB_PE   = 5;
    localparam int SB_FE   = 4;
    localparam int SB_BRK  = 3;
    localparam int SB_CIP  = 2;
    localparam int SB_SYNC = 1;
    localparam int SB_REN  = 0;
endpackage

// File: rtl/rsi_buffer.sv
module rsi_buffer
    import rsi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_done,
    input  logic [DW-1:0] char_data,
    input  logic          char_pe,
    input  logic          char_fe,
    input  logic          char_sync,
    input  logic          rd_data,
    input  logic          rd_stat,
    output logic          full,
    output logic [DW-1:0] data_q,
    output logic          pe_q,
    output logic          fe_q,
    output logic          sync_q,
    output logic          oe_q,
    output logic          hold_q,
    output logic          word_evt,
    output logic          word_err,
    output logic          reveal
);
    buf_state_e state_q, state_d;
    logic       load;
    logic       oe_set;

    // Transition logic: EMPTY->FULL on load, FULL->OVRUN on lost word,
    // FULL/OVRUN->EMPTY on data read.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        reveal  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (char_done && !hold_q) begin
                    state_d = ST_FULL;
                    load    = 1'b1;
                end
            end
            ST_FULL: begin
                if (rd_data) begin
                    state_d = ST_EMPTY;
                    reveal  = 1'b1;
                end else if (char_done) begin
                    state_d = ST_OVRUN;
                end
            end
            ST_OVRUN: begin
                if (rd_data) begin
                    state_d = ST_EMPTY;
                    reveal  = 1'b1;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign oe_set   = reveal && (state_q == ST_OVRUN);
    assign word_evt = load || oe_set;
    assign word_err = load ? (char_pe || char_fe || char_sync) : 1'b1;
    assign full     = (state_q != ST_EMPTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            sync_q <= 1'b0;
            oe_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (load) begin
                data_q <= char_data;
                pe_q   <= char_pe;
                fe_q   <= char_fe;
                sync_q <= char_sync;
            end
            if (oe_set) begin
                oe_q   <= 1'b1;
                hold_q <= 1'b1;
            end else if (rd_stat) begin
                oe_q   <= 1'b0;
                hold_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rsi_break.sv
module rsi_break (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_start,
    input  logic brk_end,
    input  logic full,
    input  logic reveal,
    input  logic rd_stat,
    output logic b_q,
    output logic brk_evt
);
    logic brk_pend_q;
    logic end_pend_q;
    logic b_set;
    logic end_now;
    logic end_rel;

    assign b_set   = (brk_start && !full) || (reveal && brk_pend_q);
    assign end_now = brk_end && !b_q && !brk_pend_q;
    assign end_rel = rd_stat && end_pend_q && !brk_pend_q;
    assign brk_evt = b_set || end_now || end_rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q        <= 1'b0;
            brk_pend_q <= 1'b0;
            end_pend_q <= 1'b0;
        end else begin
            if (b_set)        b_q <= 1'b1;
            else if (rd_stat) b_q <= 1'b0;

            if (brk_start && full) brk_pend_q <= 1'b1;
            else if (reveal)       brk_pend_q <= 1'b0;

            if (brk_end && (b_q || brk_pend_q)) end_pend_q <= 1'b1;
            else if (end_rel)                   end_pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rsi_irq_route.sv
module rsi_irq_route (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic err_ie,
    input  logic full_ie,
    input  logic word_evt,
    input  logic word_err,
    input  logic brk_evt,
    output logic irq_err,
    output logic irq_full
);
    logic to_err;
    logic to_full;

    assign to_err  = err_ie && ((word_evt && word_err) || brk_evt);
    assign to_full = (word_evt && !(word_err && err_ie)) || (brk_evt && !err_ie);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_err  <= 1'b0;
            irq_full <= 1'b0;
        end else begin
            irq_err  <= rx_en && to_err;
            irq_full <= rx_en && full_ie && to_full;
        end
    end
endmodule

// File: rtl/rx_stat_irq_ctrl.sv
module rx_stat_irq_ctrl
    import rsi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              char_busy,
    input  logic              char_done,
    input  logic [DW-1:0]     char_data,
    input  logic              char_pe,
    input  logic              char_fe,
    input  logic              char_sync,
    input  logic              brk_start,
    input  logic              brk_end,
    input  logic              err_ie,
    input  logic              full_ie,
    input  logic              rd_stat,
    input  logic              rd_data,
    output logic [STAT_W-1:0] stat,
    output logic [DW-1:0]     data_out,
    output logic              irq_full,
    output logic              irq_err,
    output logic              asm_hold
);
    logic full, pe_q, fe_q, sync_q, oe_q, b_q;
    logic word_evt, word_err, reveal, brk_evt;

    rsi_buffer #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_done(char_done),
        .char_data(char_data),
        .char_pe  (char_pe),
        .char_fe  (char_fe),
        .char_sync(char_sync),
        .rd_data  (rd_data),
        .rd_stat  (rd_stat),
        .full     (full),
        .data_q   (data_out),
        .pe_q     (pe_q),
        .fe_q     (fe_q),
        .sync_q   (sync_q),
        .oe_q     (oe_q),
        .hold_q   (asm_hold),
        .word_evt (word_evt),
        .word_err (word_err),
        .reveal   (reveal)
    );

    rsi_break u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_start(brk_start),
        .brk_end  (brk_end),
        .full     (full),
        .reveal   (reveal),
        .rd_stat  (rd_stat),
        .b_q      (b_q),
        .brk_evt  (brk_evt)
    );

    rsi_irq_route u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .err_ie  (err_ie),
        .full_ie (full_ie),
        .word_evt(word_evt),
        .word_err(word_err),
        .brk_evt (brk_evt),
        .irq_err (irq_err),
        .irq_full(irq_full)
    );

    always_comb begin
        stat          = '0;
        stat[SB_FULL] = full;
        stat[SB_OE]   = oe_q;
        stat[SB_PE]   = pe_q;
        stat[SB_FE]   = fe_q;
        stat[SB_BRK]  = b_q;
        stat[SB_CIP]  = char_busy;
        stat[SB_SYNC] = sync_q;
        stat[SB_REN]  = rx_en;
    end
endmodule

// File: rtl/rx_stat_irq_ctrl_chk.sv
module rx_stat_irq_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          char_done,
    input logic          rd_data,
    input logic          rd_stat,
    input logic [7:0]    stat,
    input logic [DW-1:0] data_out,
    input logic          irq_full,
    input logic          irq_err,
    input logic          asm_hold
);
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({irq_err, irq_full})); // R3
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> (!irq_err && !irq_full)); // R11
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (stat[7] && !rd_data) |=> ($stable(data_out) && $stable(stat[5:4]) && $stable(stat[1]))); // R4
    AST_OE_ON_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[6]) |-> $past(rd_data)); // R5
    AST_HOLD_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (asm_hold && char_done && !stat[7]) |=> !stat[7]); // R6
    AST_DATA_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) rd_data |=> !stat[7]); // R7
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rd_stat |=> (!stat[6] && !stat[3] && !asm_hold)); // R7
endmodule

bind rx_stat_irq_ctrl rx_stat_irq_ctrl_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .char_done(char_done),
    .rd_data  (rd_data),
    .rd_stat  (rd_stat),
    .stat     (stat),
    .data_out (data_out),
    .irq_full (irq_full),
    .irq_err  (irq_err),
    .asm_hold (asm_hold)
);

// File: tb/sim_rx_stat_irq_ctrl.sv
`timescale 1ns/1ps
module sim_rx_stat_irq_ctrl;
    localparam int DW = 8;
    localparam int OP_NOP  = 0;
    localparam int OP_LOAD = 1;
    localparam int OP_RDD  = 2;
    localparam int OP_RDS  = 3;
    localparam int OP_BS   = 4;
    localparam int OP_BE   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, char_busy = 1'b0, char_done = 1'b0;
    logic [DW-1:0] char_data = '0;
    logic char_pe = 1'b0, char_fe = 1'b0, char_sync = 1'b0;
    logic brk_start = 1'b0, brk_end = 1'b0;
    logic err_ie = 1'b0, full_ie = 1'b0, rd_stat = 1'b0, rd_data = 1'b0;
    logic [7:0] stat;
    logic [DW-1:0] data_out;
    logic irq_full, irq_err, asm_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected-state model
    logic m_bf = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_sy = 0, m_b = 0;
    logic m_ovp = 0, m_brkp = 0, m_endp = 0, m_hold = 0;
    logic [DW-1:0] m_data = '0;
    logic e_err = 0, e_full = 0;

    always #4 clk = ~clk;

    rx_stat_irq_ctrl #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_busy(char_busy),
        .char_done(char_done), .char_data(char_data), .char_pe(char_pe),
        .char_fe(char_fe), .char_sync(char_sync), .brk_start(brk_start),
        .brk_end(brk_end), .err_ie(err_ie), .full_ie(full_ie),
        .rd_stat(rd_stat), .rd_data(rd_data), .stat(stat), .data_out(data_out),
        .irq_full(irq_full), .irq_err(irq_err), .asm_hold(asm_hold)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {m_bf, m_oe, m_pe, m_fe, m_b, char_busy, m_sy, rx_en};
    endfunction

    task automatic model_step(input int op, input logic [DW-1:0] d, input logic pe, input logic fe, input logic sy);
        logic we, werr, bev;
        we = 0; werr = 0; bev = 0;
        case (op)
            OP_LOAD: begin
                if (!m_bf && !m_hold) begin
                    m_bf = 1; m_data = d; m_pe = pe; m_fe = fe; m_sy = sy;
                    we = 1; werr = pe | fe | sy;
                end else if (m_bf) m_ovp = 1;
            end
            OP_RDD: if (m_bf) begin
                m_bf = 0;
                if (m_ovp) begin m_oe = 1; m_hold = 1; m_ovp = 0; we = 1; werr = 1; end
                if (m_brkp) begin m_b = 1; m_brkp = 0; bev = 1; end
            end
            OP_RDS: begin
                m_oe = 0; m_b = 0; m_hold = 0;
                if (m_endp && !m_brkp) begin m_endp = 0; bev = 1; end
            end
            OP_BS: begin
                if (!m_bf) begin m_b = 1; bev = 1; end
                else m_brkp = 1;
            end
            OP_BE: begin
                if (m_b || m_brkp) m_endp = 1;
                else bev = 1;
            end
            default: ;
        endcase
        e_err = 0; e_full = 0;
        if (rx_en) begin
            if (we) begin
                if (werr && err_ie) e_err = 1; else e_full = full_ie;
            end
            if (bev) begin
                if (err_ie) e_err = 1; else e_full = full_ie;
            end
        end
    endtask

    task automatic do_op(input int op, input logic [DW-1:0] d, input logic pe, input logic fe, input logic sy, input string tag);
        char_data = d; char_pe = pe; char_fe = fe; char_sync = sy;
        char_done = (op == OP_LOAD); rd_data = (op == OP_RDD); rd_stat = (op == OP_RDS);
        brk_start = (op == OP_BS); brk_end = (op == OP_BE);
        @(posedge clk);
        model_step(op, d, pe, fe, sy);
        @(negedge clk);
        char_done = 0; rd_data = 0; rd_stat = 0; brk_start = 0; brk_end = 0;
        check(tag, "stat", {24'b0, stat}, {24'b0, exp_stat()});
        check(tag, "data_out", {24'b0, data_out}, {24'b0, m_data});
        check(tag, "irq_err", {31'b0, irq_err}, {31'b0, e_err});
        check(tag, "irq_full", {31'b0, irq_full}, {31'b0, e_full});
        check(tag, "asm_hold", {31'b0, asm_hold}, {31'b0, m_hold});
    endtask

    initial begin
        #(64'd8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: act=timeout exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h00C0FFEE);
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1", "stat", {24'b0, stat}, 32'h0);
        check("R1", "irqs", {30'b0, irq_err, irq_full}, 32'h0);
        check("R1", "asm_hold", {31'b0, asm_hold}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        rx_en = 1; err_ie = 1; full_ie = 1;
        do_op(OP_NOP, 0, 0, 0, 0, "R1");

        // R2 R3: clean word to buffer-full channel
        do_op(OP_LOAD, 8'hA5, 0, 0, 0, "R2");
        do_op(OP_RDD, 0, 0, 0, 0, "R7");
        // R3: erroneous word, error channel enabled
        do_op(OP_LOAD, 8'h5A, 1, 0, 1, "R3");
        do_op(OP_RDD, 0, 0, 0, 0, "R7");
        // R3: error channel disabled -> buffer-full channel
        err_ie = 0;
        do_op(OP_LOAD, 8'h3C, 0, 1, 0, "R3");
        do_op(OP_RDD, 0, 0, 0, 0, "R7");
        err_ie = 1;
        // R4 R5 R6 R7: overrun
        do_op(OP_LOAD, 8'h11, 0, 0, 0, "R2");
        do_op(OP_LOAD, 8'h22, 1, 1, 1, "R4");
        do_op(OP_RDD, 0, 0, 0, 0, "R5");
        do_op(OP_LOAD, 8'h33, 0, 0, 0, "R6");
        do_op(OP_RDS, 0, 0, 0, 0, "R7");
        // R8 R10: break with empty buffer, end deferred to status read
        do_op(OP_BS, 0, 0, 0, 0, "R8");
        do_op(OP_BE, 0, 0, 0, 0, "R10");
        do_op(OP_RDS, 0, 0, 0, 0, "R10");
        // R9: break while full, no overrun
        do_op(OP_LOAD, 8'h44, 0, 0, 0, "R2");
        do_op(OP_BS, 0, 0, 0, 0, "R9");
        do_op(OP_BE, 0, 0, 0, 0, "R9");
        do_op(OP_RDD, 0, 0, 0, 0, "R9");
        do_op(OP_RDS, 0, 0, 0, 0, "R10");
        // R9: break ends and a word arrives before read -> B and OE
        do_op(OP_LOAD, 8'h55, 0, 0, 0, "R2");
        do_op(OP_BS, 0, 0, 0, 0, "R9");
        do_op(OP_BE, 0, 0, 0, 0, "R9");
        do_op(OP_LOAD, 8'h66, 0, 0, 0, "R4");
        do_op(OP_RDD, 0, 0, 0, 0, "R9");
        do_op(OP_RDS, 0, 0, 0, 0, "R10");
        // R8: break while OE already set
        do_op(OP_LOAD, 8'h77, 0, 0, 0, "R2");
        do_op(OP_LOAD, 8'h78, 0, 0, 0, "R4");
        do_op(OP_RDD, 0, 0, 0, 0, "R5");
        do_op(OP_BS, 0, 0, 0, 0, "R8");
        do_op(OP_RDS, 0, 0, 0, 0, "R7");
        do_op(OP_BE, 0, 0, 0, 0, "R10");
        // R11: receiver disabled / buffer-full channel disabled
        rx_en = 0;
        do_op(OP_LOAD, 8'h99, 1, 0, 0, "R11");
        do_op(OP_RDD, 0, 0, 0, 0, "R11");
        rx_en = 1; full_ie = 0;
        do_op(OP_LOAD, 8'h9A, 0, 0, 0, "R11");
        do_op(OP_RDD, 0, 0, 0, 0, "R11");
        full_ie = 1;
        char_busy = 1;
        do_op(OP_NOP, 0, 0, 0, 0, "R2");
        char_busy = 0;

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r <= 4)
                do_op(OP_LOAD, DW'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, "R2/R4");
            else if (r <= 7) do_op(OP_RDD, 0, 0, 0, 0, "R5/R9");
            else if (r <= 9) do_op(OP_RDS, 0, 0, 0, 0, "R7/R10");
            else if (r == 10) do_op(OP_BS, 0, 0, 0, 0, "R8/R9");
            else if (r == 11) do_op(OP_BE, 0, 0, 0, 0, "R10");
            else begin
                if (r == 12) err_ie = ~err_ie;
                else if (r == 13) full_ie = ($urandom % 4) != 0;
                else if (r == 14) rx_en = ($urandom % 4) != 0;
                else char_busy = $urandom % 2;
                do_op(OP_NOP, 0, 0, 0, 0, "R11");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule